// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits in the enable path between a processor and a battery-backed low-power SRAM. While the supply is good, the processor's active-low chip enable reaches the memory with no register in the way. When an external comparator reports that the supply has left tolerance, or when the battery-backup flag is raised, the gate write-protects the SRAM by holding its enable inactive. An access that was already under way when the failure was seen may finish, but only for a bounded number of cycles. When the supply comes back, the SRAM stays deselected for a fixed recovery interval before normal pass-through resumes.

The controller has four states. `ST_RUN` passes the enable through. `ST_DRAIN` lets an in-flight access finish. `ST_LOCK` holds the output inactive while the supply is bad. `ST_RECOVER` times the recovery interval. The named transitions are:
- run-to-drain: failure seen while the enable is low.
- run-to-lock: failure seen while the enable is high.
- drain-close: the access ends, the write-protect limit is reached, or the battery flag rises.
- lock-release: the supply is good and the battery flag is low.
- recover-abort: failure seen during recovery.
- recover-done: the recovery count expires.

Reset enters `ST_LOCK`, so power-up follows the same recovery path. Both intervals are parameters counted in clock cycles. The supply-valid flag is asynchronous and passes through a two-flop synchronizer.

Top module: `ce_guard`

## Requirements
- R1: During reset and after it, `ce_out_n` is 1. The block stays in lock until the synchronized supply flag is seen high, then follows the recovery rule of R8.
- R2: `supply_ok_async` passes through two flip-flops. A change on it affects the state decision at the third rising edge after it is applied. A one-cycle low pulse is not filtered.
- R3: In the run state with `batt_mode` low, `ce_out_n` equals `ce_in_n` in the same cycle (combinational path).
- R4: If a failure is seen in the run state while `ce_in_n` is 1, the output stays 1 from then on until recovery completes. Any later low on `ce_in_n` is not passed.
- R5: If a failure is seen in the run state while `ce_in_n` is 0, the block enters drain. `ce_out_n` keeps following the low enable until the access ends.
- R6: When `ce_in_n` rises during drain, the block enters lock at the next edge. A new low on `ce_in_n` after that is not passed.
- R7: Drain lasts at most `WP_CYCLES` cycles. After that many cycles, `ce_out_n` is forced to 1 even if `ce_in_n` is still 0. If the access ends in the same cycle that the limit is reached, the block also enters lock.
- R8: After lock-release, `ce_out_n` stays 1 for exactly `REC_CYCLES` cycles whatever `ce_in_n` does. Pass-through then resumes.
- R9: A failure seen during recovery returns the block to lock. This includes a failure in the last recovery cycle, which takes priority over recover-done. The full recovery interval restarts on the next release.
- R10: `batt_mode` high forces `ce_out_n` to 1 in the same cycle in every state and counts as a failure for all transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in_n | input | 1 | Processor chip enable, active low |
| supply_ok_async | input | 1 | Supply-in-tolerance flag from the comparator, asynchronous, 1 = good |
| batt_mode | input | 1 | Battery-backup mode flag, 1 = on battery |
| ce_out_n | output | 1 | Conditioned chip enable to the SRAM, active low |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is the end of an in-flight access and the expiry of the write-protect limit. The bench counts the synchronizer and state-register latency, then releases the enable exactly in the last allowed drain cycle.

The second pair is a new failure and the expiry of recovery. The bench drops the supply so that the synchronized failure reaches the state logic in the final recovery cycle.

In both cases a behavioural model in the bench, built from a supply-history queue and a phase-age count, predicts `ce_out_n` for every cycle. The output must stay inactive afterwards and must not resume pass-through.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_LOCK    = 2'd2,
        ST_RECOVER = 2'd3
    } guard_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/ce_guard_sync.sv
module ce_guard_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] pipe;

    // Reset value 0 means the supply is treated as invalid until it is seen good.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d_async};
        end
    end

    assign d_sync = pipe[STAGES-1];

endmodule

// File: rtl/ce_guard_timer.sv
module ce_guard_timer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [WIDTH-1:0] elapsed
);

    localparam logic [WIDTH-1:0] CEILING = '1;

    // Counts the cycles spent in the current state; saturates at CEILING.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (elapsed != CEILING) begin
            elapsed <= elapsed + WIDTH'(1);
        end
    end

endmodule

// File: rtl/ce_guard_fsm.sv
module ce_guard_fsm
    import ce_guard_pkg::*;
#(
    parameter int unsigned WP_CYCLES  = 16,
    parameter int unsigned REC_CYCLES = 32,
    parameter int unsigned CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_in_n,
    input  logic             supply_ok,
    input  logic             batt_mode,
    input  logic [CNT_W-1:0] elapsed,
    output guard_state_e     state_q,
    output logic             restart,
    output logic             ce_out_n
);

    localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYCLES - 1);

    guard_state_e state_d;
    logic         fail;

    assign fail = !supply_ok || batt_mode;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fail) begin
                    state_d = ce_in_n ? ST_LOCK : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ce_in_n || batt_mode || (elapsed == WP_LAST)) begin
                    state_d = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (!fail) begin
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (fail) begin
                    state_d = ST_LOCK;
                end else if (elapsed == REC_LAST) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
        end else begin
            state_q <= state_d;
        end
    end

    assign restart = (state_d != state_q);

    always_comb begin
        unique case (state_q)
            ST_RUN, ST_DRAIN: ce_out_n = ce_in_n | batt_mode;
            default:          ce_out_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/ce_guard.sv
module ce_guard
    import ce_guard_pkg::*;
#(
    parameter int unsigned WP_CYCLES  = 10000,
    parameter int unsigned REC_CYCLES = 8000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in_n,
    input  logic supply_ok_async,
    input  logic batt_mode,
    output logic ce_out_n
);

    localparam int unsigned LONGEST = (WP_CYCLES > REC_CYCLES) ? WP_CYCLES : REC_CYCLES;
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    logic             supply_sync;
    logic             restart;
    logic [CNT_W-1:0] elapsed;
    guard_state_e     state_q;

    ce_guard_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (supply_ok_async),
        .d_sync  (supply_sync)
    );

    ce_guard_timer #(
        .WIDTH (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .elapsed (elapsed)
    );

    ce_guard_fsm #(
        .WP_CYCLES  (WP_CYCLES),
        .REC_CYCLES (REC_CYCLES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_in_n   (ce_in_n),
        .supply_ok (supply_sync),
        .batt_mode (batt_mode),
        .elapsed   (elapsed),
        .state_q   (state_q),
        .restart   (restart),
        .ce_out_n  (ce_out_n)
    );

endmodule

// File: rtl/ce_guard_chk.sv
module ce_guard_chk
    import ce_guard_pkg::*;
#(
    parameter int unsigned WP_CYCLES  = 16,
    parameter int unsigned REC_CYCLES = 32,
    parameter int unsigned CNT_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_in_n,
    input logic             batt_mode,
    input logic             supply_ok,
    input guard_state_e     state,
    input logic [CNT_W-1:0] cnt,
    input logic             ce_out_n
);

    localparam logic [CNT_W-1:0] WP_LIM   = CNT_W'(WP_CYCLES);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYCLES - 1);

    // R10
    batt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        batt_mode |-> ce_out_n);

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |=> ce_out_n);

    // R5
    drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !supply_ok && !ce_in_n && !batt_mode) |=> (state == ST_DRAIN));

    // R6
    drain_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && ce_in_n) |=> (state == ST_LOCK && ce_out_n));

    // R7
    wp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (cnt < WP_LIM));

    // R8
    rec_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && supply_ok && !batt_mode && cnt == REC_LAST) |=> (state == ST_RUN));

    // R9
    rec_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && !supply_ok) |=> (state == ST_LOCK));

endmodule

bind ce_guard ce_guard_chk #(
    .WP_CYCLES  (WP_CYCLES),
    .REC_CYCLES (REC_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_in_n   (ce_in_n),
    .batt_mode (batt_mode),
    .supply_ok (supply_sync),
    .state     (state_q),
    .cnt       (elapsed),
    .ce_out_n  (ce_out_n)
);

// File: tb/tb_ce_guard.sv
`timescale 1ns/1ps
module tb_ce_guard;

    localparam int unsigned WP_C  = 8;
    localparam int unsigned REC_C = 20;

    localparam int P_RUN = 0;
    localparam int P_DRN = 1;
    localparam int P_LCK = 2;
    localparam int P_REC = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic ce_in_n;
    logic supply;
    logic batt;
    logic ce_out_n;

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";
    bit    done  = 0;

    int m_phase = P_LCK;
    int m_age   = 0;
    int supply_hist[$];

    always #5 clk = ~clk;

    ce_guard #(
        .WP_CYCLES  (WP_C),
        .REC_CYCLES (REC_C)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ce_in_n         (ce_in_n),
        .supply_ok_async (supply),
        .batt_mode       (batt),
        .ce_out_n        (ce_out_n)
    );

    // Behavioural reference: supply history queue plus phase and age in phase.
    always @(posedge clk or negedge rst_n) begin
        int  nxt;
        bit  seen_ok;
        bit  fail;
        if (!rst_n) begin
            m_phase = P_LCK;
            m_age   = 0;
            supply_hist = '{0, 0};
        end else begin
            seen_ok = supply_hist[0] != 0;
            fail    = !seen_ok || batt;
            nxt     = m_phase;
            case (m_phase)
                P_RUN: if (fail) nxt = ce_in_n ? P_LCK : P_DRN;
                P_DRN: if (ce_in_n || batt || m_age == WP_C - 1) nxt = P_LCK;
                P_LCK: if (!fail) nxt = P_REC;
                default: begin
                    if (fail) nxt = P_LCK;
                    else if (m_age == REC_C - 1) nxt = P_RUN;
                end
            endcase
            if (nxt != m_phase) m_age = 0;
            else m_age++;
            m_phase = nxt;
            void'(supply_hist.pop_front());
            supply_hist.push_back(int'(supply));
        end
    end

    always @(negedge clk) begin
        logic exp;
        if (!done) begin
            if (batt) exp = 1'b1;
            else if (m_phase == P_RUN || m_phase == P_DRN) exp = ce_in_n;
            else exp = 1'b1;
            total++;
            if (ce_out_n !== exp) begin
                bad++;
                $display("FAIL %s: ce_out_n=%b expected=%b at %0t", tag, ce_out_n, exp, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        rst_n = 1'b0; ce_in_n = 1'b1; supply = 1'b0; batt = 1'b0;
        tag = "R1";
        step(4);
        rst_n = 1'b1;
        step(5);

        // Power-up recovery, enable held low throughout
        tag = "R8";
        supply = 1'b1; ce_in_n = 1'b0;
        step(REC_C + 3);
        ce_in_n = 1'b1;
        step(2);

        tag = "R3";
        for (int i = 0; i < 12; i++) begin
            ce_in_n = logic'(i[0] ^ i[2]);
            step(1);
        end
        ce_in_n = 1'b1;
        step(1);

        // Failure while idle, later access attempts blocked
        tag = "R4";
        supply = 1'b0;
        step(2);
        ce_in_n = 1'b0;
        step(6);
        ce_in_n = 1'b1;
        step(2);
        tag = "R8";
        supply = 1'b1;
        step(REC_C + 5);

        // Short in-flight access, then a new attempt
        tag = "R5";
        ce_in_n = 1'b0;
        step(2);
        supply = 1'b0;
        step(4);
        tag = "R6";
        ce_in_n = 1'b1;
        step(2);
        ce_in_n = 1'b0;
        step(4);
        ce_in_n = 1'b1;
        supply = 1'b1;
        tag = "R8";
        step(REC_C + 5);

        // Access longer than the write-protect limit
        tag = "R7";
        ce_in_n = 1'b0;
        step(1);
        supply = 1'b0;
        step(WP_C + 6);
        ce_in_n = 1'b1;
        supply = 1'b1;
        step(REC_C + 5);

        // Access ends in the final drain cycle
        tag = "R7";
        ce_in_n = 1'b0;
        step(1);
        supply = 1'b0;
        step(WP_C + 2);
        ce_in_n = 1'b1;
        step(3);
        ce_in_n = 1'b0;
        step(2);
        ce_in_n = 1'b1;
        supply = 1'b1;
        step(REC_C + 5);

        // Recovery interrupted mid-way and in its last cycle
        tag = "R9";
        supply = 1'b0;
        step(4);
        supply = 1'b1;
        ce_in_n = 1'b0;
        step(10);
        supply = 1'b0;
        step(3);
        supply = 1'b1;
        step(REC_C);
        supply = 1'b0;
        step(4);
        supply = 1'b1;
        step(REC_C + 5);
        ce_in_n = 1'b1;
        step(2);

        tag = "R10";
        ce_in_n = 1'b0;
        step(2);
        batt = 1'b1;
        step(3);
        batt = 1'b0;
        step(3);
        ce_in_n = 1'b1;
        step(REC_C + 5);

        // One-cycle supply dip travels through the synchronizer
        tag = "R2";
        ce_in_n = 1'b0;
        step(1);
        supply = 1'b0;
        step(1);
        supply = 1'b1;
        step(8);
        ce_in_n = 1'b1;
        step(REC_C + 5);
        ce_in_n = 1'b0;
        step(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule